// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 64-bit effective address of a memory access from the fields of a decoded load or store. Two encodings reach it. The compact encoding adds a sign-extended 16-bit offset to a base. The extended encoding adds three terms: a base, an index shifted left by 0 to 3 places, and a displacement that is either absent, a sign-extended 32-bit word, or a full 64-bit word. Register number 0 has a meaning that depends on where it appears. As the base it selects the current instruction pointer. As the index it selects the constant zero.

The address is registered. It appears one clock after a request is presented, together with the access size, the signedness and an atomic-event mark, so that the data-alignment stage downstream can use them. When no request is presented, the output register keeps its contents. The block does not perform cache lookup, translation or reservation tracking.

Top module: `eff_addr_unit`

## Requirements
- R1: In the compact form (`req_long`=0) the address is base + sign-extension of `disp_val[15:0]`. Bits 63:16 of `disp_val` have no effect.
- R2: When `base_idx` is 0, `ip_val` replaces `base_val` as the base, in both forms.
- R3: In the extended form the index term is `index_val` shifted left by `scale_sh` (0..3), which gives a factor of 1, 2, 4 or 8. Bits shifted out are lost.
- R4: In the extended form, when `index_idx` is 0 the index term is zero, whatever `index_val` holds.
- R5: In the compact form, `index_idx`, `index_val`, `scale_sh` and `disp_kind` have no effect on the address.
- R6: In the extended form, `disp_kind` selects the displacement: 2'b00 gives zero, 2'b01 gives the sign-extension of `disp_val[31:0]`, 2'b10 gives all 64 bits of `disp_val`, and 2'b11 gives zero.
- R7: All address sums wrap modulo 2^64.
- R8: `out_size` and `out_signed` equal the `acc_size` and `acc_signed` of the request that produced the address.
- R9: `out_atomic` equals `atomic_in` for an extended-form request and is 0 for a compact-form request.
- R10: `out_valid` rises in the cycle after a request with `req_valid`=1. When `req_valid`=0, `out_valid` is 0 in the next cycle and all data outputs hold their values.
- R11: While `rst_n` is low, `out_valid`, `out_addr`, `out_size`, `out_signed` and `out_atomic` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released in step with clk |
| req_valid | input | 1 | A request is present this cycle |
| req_long | input | 1 | 1 = extended form, 0 = compact form |
| base_idx | input | 5 | Base register number; 0 selects the instruction pointer |
| index_idx | input | 5 | Index register number; 0 selects zero |
| scale_sh | input | 2 | Left shift applied to the index |
| disp_kind | input | 2 | Extended-form displacement selector (see R6) |
| disp_val | input | 64 | Raw displacement bits |
| base_val | input | 64 | Value read from the base register |
| index_val | input | 64 | Value read from the index register |
| ip_val | input | 64 | Current instruction pointer |
| acc_size | input | 2 | Access size code, passed through |
| acc_signed | input | 1 | Sign-extend loaded data, passed through |
| atomic_in | input | 1 | Atomic-event mark from the extended form |
| out_valid | output | 1 | Registered address is valid |
| out_addr | output | 64 | Effective address |
| out_size | output | 2 | Registered access size |
| out_signed | output | 1 | Registered signedness |
| out_atomic | output | 1 | Registered atomic mark |

## Verification
The bound checker checks the following on every cycle: the one-cycle valid timing and the hold of the data outputs, the pass-through of size and signedness, the clearing of the atomic mark for compact requests, and two narrow address identities. The identities are that an extended request with a zero index and no displacement yields exactly the base, and that a compact request with base 0 and a zero offset yields exactly the instruction pointer. Only the bench scenarios can show the full arithmetic. That covers the sign extension of negative 16- and 32-bit offsets, each shift amount, the reserved displacement code, the masking of unused displacement bits, and wraparound past 2^64.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'b00,
    DISP_W32  = 2'b01,
    DISP_W64  = 2'b10,
    DISP_RSVD = 2'b11
  } disp_kind_e;

  typedef struct packed {
    logic [1:0] size;
    logic       sgn;
    logic       atomic;
  } acc_attr_t;

endpackage

// File: rtl/agu_base_sel.sv
module agu_base_sel #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] ip_val,
  output logic [ADDR_W-1:0] base_term
);
  // Register number zero in the base slot stands for the instruction pointer.
  logic use_ip;

  always_comb begin
    use_ip    = (base_idx == '0);
    base_term = use_ip ? ip_val : base_val;
  end
endmodule

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned SH_W   = 2
) (
  input  logic              is_long,
  input  logic [IDX_W-1:0]  index_idx,
  input  logic [SH_W-1:0]   scale_sh,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] index_term
);
  localparam int unsigned NUM_SCALE = 1 << SH_W;

  logic [ADDR_W-1:0] scaled [NUM_SCALE];
  logic              idx_live;

  // One pre-shifted candidate per legal shift amount.
  for (genvar s = 0; s < NUM_SCALE; s++) begin : g_scale
    assign scaled[s] = index_val << s;
  end

  always_comb begin
    // Register number zero in the index slot stands for the constant zero.
    idx_live   = is_long && (index_idx != '0);
    index_term = idx_live ? scaled[scale_sh] : '0;
  end
endmodule

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned MID_W   = 32
) (
  input  logic              is_long,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] disp_raw,
  output logic [ADDR_W-1:0] disp_term
);
  localparam int unsigned SHORT_PAD = ADDR_W - SHORT_W;
  localparam int unsigned MID_PAD   = ADDR_W - MID_W;

  logic [ADDR_W-1:0] short_ext;
  logic [ADDR_W-1:0] mid_ext;
  disp_kind_e        kind_e;

  always_comb begin
    short_ext = {{SHORT_PAD{disp_raw[SHORT_W-1]}}, disp_raw[SHORT_W-1:0]};
    mid_ext   = {{MID_PAD{disp_raw[MID_W-1]}}, disp_raw[MID_W-1:0]};
    kind_e    = disp_kind_e'(kind);
    if (!is_long) begin
      disp_term = short_ext;
    end else begin
      unique case (kind_e)
        DISP_W32: disp_term = mid_ext;
        DISP_W64: disp_term = disp_raw;
        default:  disp_term = '0;
      endcase
    end
  end
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import agu_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned SH_W    = 2,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned MID_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_long,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [IDX_W-1:0]  index_idx,
  input  logic [SH_W-1:0]   scale_sh,
  input  logic [1:0]        disp_kind,
  input  logic [ADDR_W-1:0] disp_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [ADDR_W-1:0] ip_val,
  input  logic [1:0]        acc_size,
  input  logic              acc_signed,
  input  logic              atomic_in,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_size,
  output logic              out_signed,
  output logic              out_atomic
);
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] sum_c;
  acc_attr_t         attr_c;

  logic [ADDR_W-1:0] addr_d, addr_q;
  acc_attr_t         attr_d, attr_q;
  logic              valid_d, valid_q;

  agu_base_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_base (
    .base_idx (base_idx),
    .base_val (base_val),
    .ip_val   (ip_val),
    .base_term(base_term)
  );

  agu_index_scale #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SH_W(SH_W)) u_index (
    .is_long   (req_long),
    .index_idx (index_idx),
    .scale_sh  (scale_sh),
    .index_val (index_val),
    .index_term(index_term)
  );

  agu_disp_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .MID_W(MID_W)) u_disp (
    .is_long  (req_long),
    .kind     (disp_kind),
    .disp_raw (disp_val),
    .disp_term(disp_term)
  );

  // Next-state logic: sum the three terms, capture only on a request.
  always_comb begin
    sum_c         = base_term + index_term + disp_term;
    attr_c.size   = acc_size;
    attr_c.sgn    = acc_signed;
    attr_c.atomic = req_long & atomic_in;
    valid_d       = req_valid;
    addr_d        = req_valid ? sum_c  : addr_q;
    attr_d        = req_valid ? attr_c : attr_q;
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      attr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      addr_q  <= addr_d;
      attr_q  <= attr_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_addr   = addr_q;
  assign out_size   = attr_q.size;
  assign out_signed = attr_q.sgn;
  assign out_atomic = attr_q.atomic;
endmodule

// File: rtl/eff_addr_unit_chk.sv
module eff_addr_unit_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_long,
  input logic [IDX_W-1:0]  base_idx,
  input logic [IDX_W-1:0]  index_idx,
  input logic [1:0]        disp_kind,
  input logic [ADDR_W-1:0] disp_val,
  input logic [ADDR_W-1:0] base_val,
  input logic [ADDR_W-1:0] ip_val,
  input logic [1:0]        acc_size,
  input logic              acc_signed,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_size,
  input logic              out_signed,
  input logic              out_atomic
);
  p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_addr) && $stable(out_size)
                    && $stable(out_signed) && $stable(out_atomic)));

  p_attr_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_size == $past(acc_size) && out_signed == $past(acc_signed)));

  p_short_no_atomic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long) |=> !out_atomic);

  p_zero_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_long && index_idx == '0 && disp_kind == 2'b00 && base_idx != '0)
      |=> out_addr == $past(base_val));

  p_ip_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_long && base_idx == '0 && disp_val[15:0] == 16'h0)
      |=> out_addr == $past(ip_val));
endmodule

bind eff_addr_unit eff_addr_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_long  (req_long),
  .base_idx  (base_idx),
  .index_idx (index_idx),
  .disp_kind (disp_kind),
  .disp_val  (disp_val),
  .base_val  (base_val),
  .ip_val    (ip_val),
  .acc_size  (acc_size),
  .acc_signed(acc_signed),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .out_size  (out_size),
  .out_signed(out_signed),
  .out_atomic(out_atomic)
);

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  tag;
    logic        lng;
    logic [4:0]  bidx;
    logic [4:0]  iidx;
    logic [1:0]  sh;
    logic [1:0]  dk;
    logic [63:0] disp;
    logic [63:0] bval;
    logic [63:0] ival;
    logic [63:0] ip;
    logic [1:0]  size;
    logic        sgn;
    logic        atom;
    logic [63:0] exp_addr;
    logic        exp_atom;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 compact, positive offset
    '{8'd1, 1'b0, 5'd3, 5'd0, 2'd0, 2'd0, 64'h10, 64'h1000, 64'h0, 64'h0, 2'd0, 1'b1, 1'b0, 64'h1010, 1'b0},
    // R1 compact, negative offset, upper disp bits set and ignored
    '{8'd1, 1'b0, 5'd3, 5'd0, 2'd0, 2'd0, 64'hABCD_0000_1234_FFF0, 64'h1000, 64'h0, 64'h0, 2'd1, 1'b0, 1'b0, 64'h0FF0, 1'b0},
    // R2 compact, base 0 selects the instruction pointer
    '{8'd2, 1'b0, 5'd0, 5'd0, 2'd0, 2'd0, 64'h8, 64'hDEAD, 64'h0, 64'h4000, 2'd2, 1'b1, 1'b0, 64'h4008, 1'b0},
    // R3 scale by 8
    '{8'd3, 1'b1, 5'd2, 5'd5, 2'd3, 2'd0, 64'h0, 64'h100, 64'h10, 64'h0, 2'd3, 1'b0, 1'b0, 64'h180, 1'b0},
    // R3 scale by 2
    '{8'd3, 1'b1, 5'd2, 5'd5, 2'd1, 2'd0, 64'h0, 64'h100, 64'h7, 64'h0, 2'd0, 1'b0, 1'b0, 64'h10E, 1'b0},
    // R3 scale by 1
    '{8'd3, 1'b1, 5'd2, 5'd5, 2'd0, 2'd0, 64'h0, 64'h100, 64'h7, 64'h0, 2'd0, 1'b0, 1'b0, 64'h107, 1'b0},
    // R4 index 0 gives zero even with a live index value
    '{8'd4, 1'b1, 5'd6, 5'd0, 2'd2, 2'd0, 64'h0, 64'h200, 64'h5555, 64'h0, 2'd1, 1'b1, 1'b0, 64'h200, 1'b0},
    // R5 compact ignores the index fields and disp_kind
    '{8'd5, 1'b0, 5'd1, 5'd4, 2'd3, 2'd2, 64'h0, 64'h300, 64'h999, 64'h0, 2'd2, 1'b0, 1'b0, 64'h300, 1'b0},
    // R6 32-bit displacement, negative, upper half ignored
    '{8'd6, 1'b1, 5'd1, 5'd0, 2'd0, 2'd1, 64'h1234_5678_FFFF_FFFC, 64'h1000, 64'h0, 64'h0, 2'd3, 1'b1, 1'b0, 64'hFFC, 1'b0},
    // R6 64-bit displacement with instruction-pointer base
    '{8'd6, 1'b1, 5'd0, 5'd0, 2'd0, 2'd2, 64'h1_0000_0000, 64'h0, 64'h0, 64'h10, 2'd3, 1'b0, 1'b0, 64'h1_0000_0010, 1'b0},
    // R6 reserved code adds nothing
    '{8'd6, 1'b1, 5'd1, 5'd0, 2'd0, 2'd3, 64'hFFFF, 64'h50, 64'h0, 64'h0, 2'd0, 1'b1, 1'b0, 64'h50, 1'b0},
    // R7 sum wraps past 2^64
    '{8'd7, 1'b1, 5'd1, 5'd2, 2'd2, 2'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 64'h0, 2'd1, 1'b0, 1'b0, 64'h10, 1'b0},
    // R7 shifted-out index bit is lost
    '{8'd7, 1'b1, 5'd1, 5'd2, 2'd1, 2'd0, 64'h0, 64'h10, 64'h8000_0000_0000_0001, 64'h0, 2'd0, 1'b0, 1'b0, 64'h12, 1'b0},
    // R9 extended form carries the atomic mark; R2 with index and disp
    '{8'd9, 1'b1, 5'd0, 5'd3, 2'd0, 2'd1, 64'h20, 64'h0, 64'h1, 64'h1000, 2'd3, 1'b0, 1'b1, 64'h1021, 1'b1},
    // R9 compact form drops the atomic mark
    '{8'd9, 1'b0, 5'd2, 5'd0, 2'd0, 2'd0, 64'h4, 64'h40, 64'h0, 64'h0, 2'd2, 1'b1, 1'b1, 64'h44, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_long, acc_signed, atomic_in;
  logic [4:0]  base_idx, index_idx;
  logic [1:0]  scale_sh, disp_kind, acc_size;
  logic [63:0] disp_val, base_val, index_val, ip_val;
  logic        out_valid, out_signed, out_atomic;
  logic [63:0] out_addr;
  logic [1:0]  out_size;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_long(req_long),
    .base_idx(base_idx), .index_idx(index_idx), .scale_sh(scale_sh),
    .disp_kind(disp_kind), .disp_val(disp_val), .base_val(base_val),
    .index_val(index_val), .ip_val(ip_val), .acc_size(acc_size),
    .acc_signed(acc_signed), .atomic_in(atomic_in), .out_valid(out_valid),
    .out_addr(out_addr), .out_size(out_size), .out_signed(out_signed),
    .out_atomic(out_atomic)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic valid);
    req_valid  = valid;
    req_long   = v.lng;
    base_idx   = v.bidx;
    index_idx  = v.iidx;
    scale_sh   = v.sh;
    disp_kind  = v.dk;
    disp_val   = v.disp;
    base_val   = v.bval;
    index_val  = v.ival;
    ip_val     = v.ip;
    acc_size   = v.size;
    acc_signed = v.sgn;
    atomic_in  = v.atom;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    string tag;
    vec_t  last;
    rst_n = 1'b0;
    apply(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {63'b0, out_valid}, 64'h0);
    check("R11 out_addr", out_addr, 64'h0);
    check("R11 attrs", {59'b0, out_size, out_signed, out_atomic}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 1'b1);
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VECS[i].tag, i);
      check({tag, " addr"}, out_addr, VECS[i].exp_addr);
      check({tag, " R10 valid"}, {63'b0, out_valid}, 64'h1);
      check({tag, " R8 size"}, {62'b0, out_size}, {62'b0, VECS[i].size});
      check({tag, " R8 signed"}, {63'b0, out_signed}, {63'b0, VECS[i].sgn});
      check({tag, " R9 atomic"}, {63'b0, out_atomic}, {63'b0, VECS[i].exp_atom});
    end

    // R10 no request: outputs hold while inputs change
    last = VECS[NV-1];
    apply(VECS[3], 1'b0);
    @(negedge clk);
    check("R10 valid low", {63'b0, out_valid}, 64'h0);
    check("R10 addr hold", out_addr, last.exp_addr);
    check("R10 size hold", {62'b0, out_size}, {62'b0, last.size});
    @(negedge clk);
    check("R10 addr hold 2", out_addr, last.exp_addr);

    // R5 back-to-back: compact request with a huge index must not move the sum
    apply(VECS[7], 1'b1);
    index_val = 64'hFFFF_FFFF_FFFF_FFFF;
    index_idx = 5'd9;
    @(negedge clk);
    check("R5 index ignored", out_addr, 64'h300);

    // R11 reset during operation clears the outputs
    rst_n = 1'b0;
    #1;
    check("R11 async valid", {63'b0, out_valid}, 64'h0);
    check("R11 async addr", out_addr, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 idle after reset", {63'b0, out_valid}, 64'h0);

    finish_run();
  end
endmodule